// File: doc/BRIEF.md
# Masked Multi-Window Host I/O Decoder

This block decides whether a 16-bit host I/O cycle belongs to one of a small set of logical devices. It keeps one 32-bit window register per device. Each register holds a base address, an enable flag, a fixed device/frame identity and a fixed 8-bit mask. Every enabled window is compared against the incoming address in the same cycle. Address bits whose mask bit is set are left out of the comparison, so one window can cover a block of up to 256 byte locations.

On a match the decoder claims the cycle and reports the logical device number. It also produces a translated peripheral-bus address: the frame number times 0x400, plus the masked offset. When more than one window matches, a combinational overlap flag goes high and two sticky status bits are set. Software clears those bits by writing 1 to them.

Window registers are programmed through a simple byte-enabled write port. One designated window takes its address only as a full 16-bit update. A low-byte write lands in a shadow, and the following high-byte write commits both bytes together. There are two resets. The power-on reset clears everything. The host reset clears the other windows and the status, but the designated window keeps its enable bit and reloads its address from an init input.

Top module: `iowin_decoder`

## Requirements
- R1: A window register reads back as bits 31:16 base address, bit 15 enable, bit 14 device bit (always 0), bits 13:8 frame (FRAME_BASE plus the window index), and bits 7:0 mask (byte i of MASK_INIT). Writes cannot change bits 14:0 except the enable bit.
- R2: A window whose enable bit is 0 never matches, even when its address agrees.
- R3: Mask bit i (i = 0..7) removes address bit i from the comparison; every other bit must be equal for a match.
- R4: io_claim is high in the same cycle as io_req when at least one enabled window matches, and low whenever io_req is low or nothing matches.
- R5: io_ldn is {device bit, frame} of the lowest-indexed matching window; io_ldn and io_paddr are 0 when the cycle is not claimed.
- R6: io_paddr equals frame×0x400 plus (io_addr AND mask) of the reported window.
- R7: When two or more enabled windows match a request, io_multi is high in that cycle, and from the next cycle st_int_err and st_conflict are both 1 and stay 1.
- R8: A status write with st_wdata bit 0 = 1 clears st_int_err and with bit 1 = 1 clears st_conflict. An overlap in the same cycle wins over the clear.
- R9: For the designated window (SHADOW_IDX), a write of byte 2 alone only loads a shadow and leaves the address unchanged. A write of byte 3 sets the address to {byte 3, shadow}. When bytes 2 and 3 are written together, the address takes both new bytes.
- R10: For every other window, a write of byte 2 or byte 3 updates that address byte at once, and a write of byte 1 sets the enable bit from data bit 15.
- R11: A host reset loads the designated window's address from init_addr and keeps its enable bit. It clears the address and enable bit of every other window, and clears both status bits.
- R12: A power-on reset clears every address, every enable bit (the designated window's included) and both status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, asynchronous, active low |
| host_rst_n | input | 1 | Host reset, synchronous, active low |
| init_addr | input | 16 | Address reloaded into the designated window on host reset |
| wr_en | input | 1 | Window register write strobe |
| wr_idx | input | 2 | Window register index for writes |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 2 | Window register index for readback |
| rd_data | output | 32 | Readback of the selected window register |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 2 | Write-1-to-clear data: bit 0 internal error, bit 1 conflict |
| st_int_err | output | 1 | Sticky internal-error status |
| st_conflict | output | 1 | Sticky conflict status |
| io_req | input | 1 | Host I/O cycle address valid |
| io_addr | input | 16 | Host I/O address |
| io_claim | output | 1 | Cycle claimed |
| io_multi | output | 1 | More than one window matched this cycle |
| io_ldn | output | 7 | Logical device number of the reported window |
| io_paddr | output | 16 | Translated peripheral-bus address |

## Verification
The bench probes addresses that differ from a base only in masked bits and only in the first unmasked bit above them. A decoder that applied the mask to the wrong bits, or ignored it, would claim the second address or miss the first. It sets up two windows that overlap, with the higher-indexed one also matching. A wrong priority would then report the wrong device, and missing conflict logic would leave the sticky bits low. It also writes a status clear in the very cycle of an overlap, which catches a design where the clear wins.

For the designated window, the bench writes a lone low byte and reads back, then writes the high byte. A design without the shadow would show a half-updated address in between. Finally, it pulses the host reset after the designated window was enabled. A design that cleared that window fully, or failed to reload it from init_addr, would read back wrong.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
    localparam int REG_W       = 32;
    localparam int ADDR_W      = 16;
    localparam int MASK_W      = 8;
    localparam int FRAME_W     = 6;
    localparam int FRAME_SHIFT = 10;
    localparam int PADDR_W     = FRAME_W + FRAME_SHIFT;
    localparam int LDN_W       = FRAME_W + 1;
    localparam int BE_W        = REG_W / 8;

    // Bit positions in the window register that software relies on.
    localparam int F_EN_BIT    = 15;
    localparam int F_DEV_BIT   = 14;

    // Status write-one-to-clear bit positions.
    localparam int ST_ERR_BIT  = 0;
    localparam int ST_CONF_BIT = 1;

    typedef struct packed {
        logic int_err;
        logic conflict;
    } iowin_status_t;
endpackage

// File: rtl/iowin_regfile.sv
module iowin_regfile
    import iowin_pkg::*;
#(
    parameter int                          NUM_WIN    = 4,
    parameter int                          SHADOW_IDX = 0,
    parameter logic [FRAME_W-1:0]          FRAME_BASE = 6'd1,
    parameter logic [NUM_WIN*MASK_W-1:0]   MASK_INIT  = 32'h0F00_0703,
    localparam int                         IDX_W      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                               clk,
    input  logic                               por_rst_n,
    input  logic                               host_rst_n,
    input  logic [ADDR_W-1:0]                  init_addr,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [BE_W-1:0]                    wr_be,
    input  logic [REG_W-1:0]                   wr_data,
    input  logic [IDX_W-1:0]                   rd_idx,
    output logic [REG_W-1:0]                   rd_data,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]     win_base,
    output logic [NUM_WIN-1:0]                 win_en,
    output logic [NUM_WIN-1:0][FRAME_W-1:0]    win_frame,
    output logic [NUM_WIN-1:0][MASK_W-1:0]     win_mask
);
    typedef struct packed {
        logic [NUM_WIN-1:0][ADDR_W-1:0] base;
        logic [NUM_WIN-1:0]             en;
        logic [7:0]                     shadow;
    } rf_state_t;

    rf_state_t s_d, s_q;

    // Fixed identity fields, one per window.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_ident
        assign win_frame[g] = FRAME_W'(FRAME_BASE + g);
        assign win_mask[g]  = MASK_INIT[g*MASK_W +: MASK_W];
    end

    always_comb begin
        s_d = s_q;
        if (!host_rst_n) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (i != SHADOW_IDX) begin
                    s_d.base[i] = '0;
                    s_d.en[i]   = 1'b0;
                end
            end
            s_d.base[SHADOW_IDX] = init_addr;
            s_d.shadow           = '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    if (wr_be[1]) s_d.en[i] = wr_data[F_EN_BIT];
                    if (i == SHADOW_IDX) begin
                        if (wr_be[2]) s_d.shadow = wr_data[23:16];
                        if (wr_be[3]) begin
                            s_d.base[i] = {wr_data[31:24],
                                           wr_be[2] ? wr_data[23:16] : s_q.shadow};
                        end
                    end else begin
                        if (wr_be[2]) s_d.base[i][7:0]  = wr_data[23:16];
                        if (wr_be[3]) s_d.base[i][15:8] = wr_data[31:24];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) s_q <= '0;
        else            s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = {s_q.base[i], s_q.en[i], 1'b0, win_frame[i], win_mask[i]};
            end
        end
    end

    assign win_base = s_q.base;
    assign win_en   = s_q.en;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[F_DEV_BIT:0], wr_be[0]};

    // R9: a lone low-byte write leaves the designated address untouched.
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!por_rst_n)
        (host_rst_n && wr_en && wr_idx == IDX_W'(SHADOW_IDX) && wr_be[2] && !wr_be[3])
        |=> $stable(s_q.base[SHADOW_IDX]));

    // R11: host reset reloads the designated address from the init input.
    a_r11_reload: assert property (@(posedge clk) disable iff (!por_rst_n)
        !host_rst_n |=> (s_q.base[SHADOW_IDX] == $past(init_addr)));

    // R11: host reset keeps the designated enable bit.
    a_r11_keep_en: assert property (@(posedge clk) disable iff (!por_rst_n)
        !host_rst_n |=> $stable(s_q.en[SHADOW_IDX]));
endmodule

// File: rtl/iowin_match.sv
module iowin_match
    import iowin_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic                             io_req,
    input  logic [ADDR_W-1:0]                io_addr,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]   win_base,
    input  logic [NUM_WIN-1:0]               win_en,
    input  logic [NUM_WIN-1:0][FRAME_W-1:0]  win_frame,
    input  logic [NUM_WIN-1:0][MASK_W-1:0]   win_mask,
    output logic                             io_claim,
    output logic                             io_multi,
    output logic [LDN_W-1:0]                 io_ldn,
    output logic [PADDR_W-1:0]               io_paddr
);
    logic [NUM_WIN-1:0] hit;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        logic [ADDR_W-1:0] care;
        assign care   = ~{{(ADDR_W-MASK_W){1'b0}}, win_mask[g]};
        assign hit[g] = win_en[g] && (((io_addr ^ win_base[g]) & care) == '0);
    end

    always_comb begin
        logic [FRAME_W-1:0] sel_frame;
        logic [MASK_W-1:0]  sel_mask;
        int                 n_hit;
        sel_frame = '0;
        sel_mask  = '0;
        n_hit     = 0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_frame = win_frame[i];
                sel_mask  = win_mask[i];
                n_hit     = n_hit + 1;
            end
        end
        io_claim = io_req && (hit != '0);
        io_multi = io_req && (n_hit > 1);
        if (io_claim) begin
            io_ldn   = {1'b0, sel_frame};
            io_paddr = {sel_frame, {FRAME_SHIFT{1'b0}}}
                     + PADDR_W'(io_addr[MASK_W-1:0] & sel_mask);
        end else begin
            io_ldn   = '0;
            io_paddr = '0;
        end
    end
endmodule

// File: rtl/iowin_status.sv
module iowin_status
    import iowin_pkg::*;
(
    input  logic       clk,
    input  logic       por_rst_n,
    input  logic       host_rst_n,
    input  logic       st_wr,
    input  logic [1:0] st_wdata,
    input  logic       set_evt,
    output logic       st_int_err,
    output logic       st_conflict
);
    iowin_status_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!host_rst_n) begin
            st_d = '0;
        end else begin
            if (st_wr && st_wdata[ST_ERR_BIT])  st_d.int_err  = 1'b0;
            if (st_wr && st_wdata[ST_CONF_BIT]) st_d.conflict = 1'b0;
            if (set_evt) begin
                st_d.int_err  = 1'b1;
                st_d.conflict = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign st_int_err  = st_q.int_err;
    assign st_conflict = st_q.conflict;

    // R7: an overlap sets both sticky bits on the next cycle.
    a_r7_set_both: assert property (@(posedge clk) disable iff (!por_rst_n)
        (set_evt && host_rst_n) |=> (st_int_err && st_conflict));

    // R7: the conflict bit only rises after an overlap.
    a_r7_rise_cause: assert property (@(posedge clk) disable iff (!por_rst_n)
        $rose(st_conflict) |-> $past(set_evt));

    // R8: a write of 1 clears the conflict bit when no overlap coincides.
    a_r8_w1c: assert property (@(posedge clk) disable iff (!por_rst_n)
        (st_wr && st_wdata[ST_CONF_BIT] && !set_evt) |=> !st_conflict);
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
    import iowin_pkg::*;
#(
    parameter int                          NUM_WIN    = 4,
    parameter int                          SHADOW_IDX = 0,
    parameter logic [FRAME_W-1:0]          FRAME_BASE = 6'd1,
    parameter logic [NUM_WIN*MASK_W-1:0]   MASK_INIT  = 32'h0F00_0703,
    localparam int                         IDX_W      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                 clk,
    input  logic                 por_rst_n,
    input  logic                 host_rst_n,
    input  logic [ADDR_W-1:0]    init_addr,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [BE_W-1:0]      wr_be,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [REG_W-1:0]     rd_data,
    input  logic                 st_wr,
    input  logic [1:0]           st_wdata,
    output logic                 st_int_err,
    output logic                 st_conflict,
    input  logic                 io_req,
    input  logic [ADDR_W-1:0]    io_addr,
    output logic                 io_claim,
    output logic                 io_multi,
    output logic [LDN_W-1:0]     io_ldn,
    output logic [PADDR_W-1:0]   io_paddr
);
    logic [NUM_WIN-1:0][ADDR_W-1:0]  win_base;
    logic [NUM_WIN-1:0]              win_en;
    logic [NUM_WIN-1:0][FRAME_W-1:0] win_frame;
    logic [NUM_WIN-1:0][MASK_W-1:0]  win_mask;

    iowin_regfile #(
        .NUM_WIN    (NUM_WIN),
        .SHADOW_IDX (SHADOW_IDX),
        .FRAME_BASE (FRAME_BASE),
        .MASK_INIT  (MASK_INIT)
    ) u_regs (
        .clk        (clk),
        .por_rst_n  (por_rst_n),
        .host_rst_n (host_rst_n),
        .init_addr  (init_addr),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_be      (wr_be),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .win_base   (win_base),
        .win_en     (win_en),
        .win_frame  (win_frame),
        .win_mask   (win_mask)
    );

    iowin_match #(
        .NUM_WIN (NUM_WIN)
    ) u_match (
        .io_req    (io_req),
        .io_addr   (io_addr),
        .win_base  (win_base),
        .win_en    (win_en),
        .win_frame (win_frame),
        .win_mask  (win_mask),
        .io_claim  (io_claim),
        .io_multi  (io_multi),
        .io_ldn    (io_ldn),
        .io_paddr  (io_paddr)
    );

    iowin_status u_status (
        .clk         (clk),
        .por_rst_n   (por_rst_n),
        .host_rst_n  (host_rst_n),
        .st_wr       (st_wr),
        .st_wdata    (st_wdata),
        .set_evt     (io_multi),
        .st_int_err  (st_int_err),
        .st_conflict (st_conflict)
    );

    // R4: no claim without a request.
    a_r4_idle_no_claim: assert property (@(posedge clk) disable iff (!por_rst_n)
        !io_req |-> !io_claim);

    // R7: an overlap is always a claimed cycle.
    a_r7_multi_claims: assert property (@(posedge clk) disable iff (!por_rst_n)
        io_multi |-> io_claim);

    // R5: unclaimed cycles report device 0 and address 0.
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!por_rst_n)
        !io_claim |-> (io_ldn == '0 && io_paddr == '0));
endmodule

// File: tb/iowin_decoder_tb.sv
`timescale 1ns/1ps
module iowin_decoder_tb_top;
    logic        clk = 1'b0;
    logic        por_rst_n = 1'b0;
    logic        host_rst_n = 1'b1;
    logic [15:0] init_addr = 16'h0062;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        st_wr = 1'b0;
    logic [1:0]  st_wdata = '0;
    logic        st_int_err, st_conflict;
    logic        io_req = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_claim, io_multi;
    logic [6:0]  io_ldn;
    logic [15:0] io_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    iowin_decoder dut_i (
        .clk(clk), .por_rst_n(por_rst_n), .host_rst_n(host_rst_n),
        .init_addr(init_addr), .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .st_wr(st_wr), .st_wdata(st_wdata), .st_int_err(st_int_err),
        .st_conflict(st_conflict), .io_req(io_req), .io_addr(io_addr),
        .io_claim(io_claim), .io_multi(io_multi), .io_ldn(io_ldn), .io_paddr(io_paddr)
    );

    // Expected decode results, packed as {claim, multi, ldn[6:0], paddr[15:0]}.
    logic [24:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] idx, input logic [31:0] exp);
        @(negedge clk);
        rd_idx = idx;
        #1;
        check(tag, rd_data, exp);
    endtask

    // Driver: pushes the expected decode and applies the request for one cycle.
    task automatic probe(input string tag, input logic [15:0] a, input logic claim,
                         input logic multi, input logic [6:0] ldn, input logic [15:0] pa,
                         input logic [1:0] clr);
        @(negedge clk);
        exp_q.push_back({claim, multi, ldn, pa});
        tag_q.push_back(tag);
        io_req = 1'b1; io_addr = a;
        st_wr = (clr != 2'b00); st_wdata = clr;
        @(negedge clk);
        io_req = 1'b0; st_wr = 1'b0; st_wdata = '0;
    endtask

    task automatic st_clear(input logic [1:0] bits);
        @(negedge clk);
        st_wr = 1'b1; st_wdata = bits;
        @(negedge clk);
        st_wr = 1'b0; st_wdata = '0;
    endtask

    // Monitor: compares the design's decode against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (io_req) begin
                logic [24:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {7'd0, io_claim, io_multi, io_ldn, io_paddr}, {7'd0, e});
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R12: power-on reset with host reset inactive clears all windows.
        repeat (3) @(posedge clk);
        #1 por_rst_n = 1'b1;
        rd_check("R12 win0 after por", 2'd0, 32'h0000_0103);
        rd_check("R1 win1 layout", 2'd1, 32'h0000_0207);
        rd_check("R1 win2 layout", 2'd2, 32'h0000_0300);
        rd_check("R1 win3 layout", 2'd3, 32'h0000_040F);
        check("R12 status after por", {30'd0, st_int_err, st_conflict}, 32'd0);

        // R10/R1: program win1, read-only bits resist the write.
        wr(2'd1, 4'b1110, {16'h0300, 1'b1, 15'h7FFF});
        rd_check("R10 R1 win1 programmed", 2'd1, 32'h0300_8207);

        // R3 R5 R6: masked match on win1 (mask 07, frame 2).
        probe("R3 R6 masked hit", 16'h0305, 1, 0, 7'd2, 16'h0805, 2'b00);
        probe("R3 unmasked bit differs", 16'h0308, 0, 0, 7'd0, 16'h0000, 2'b00);

        // R4: request low gives no claim.
        @(negedge clk);
        io_addr = 16'h0305; #1;
        check("R4 no request no claim", {31'd0, io_claim}, 32'd0);

        // win2: exact match, mask 0, frame 3.
        wr(2'd2, 4'b1110, {16'h0400, 1'b1, 15'h0});
        probe("R3 R6 exact hit", 16'h0400, 1, 0, 7'd3, 16'h0C00, 2'b00);
        probe("R3 exact miss", 16'h0401, 0, 0, 7'd0, 16'h0000, 2'b00);

        // R2: win3 overlaps win1 but is disabled.
        wr(2'd3, 4'b1110, {16'h0300, 1'b0, 15'h0});
        probe("R2 disabled window ignored", 16'h0301, 1, 0, 7'd2, 16'h0801, 2'b00);
        check("R2 no status from disabled", {30'd0, st_int_err, st_conflict}, 32'd0);

        // R7 R5: enable win3, overlap reports lowest index.
        wr(2'd3, 4'b0010, {16'h0000, 1'b1, 15'h0});
        probe("R7 R5 overlap lowest wins", 16'h0302, 1, 1, 7'd2, 16'h0802, 2'b00);
        @(negedge clk); #1;
        check("R7 sticky bits set", {30'd0, st_int_err, st_conflict}, 32'd3);
        // Only win3 matches 0x030A (mask 0F, frame 4).
        probe("R5 R6 higher window alone", 16'h030A, 1, 0, 7'd4, 16'h100A, 2'b00);
        @(negedge clk); #1;
        check("R7 sticky stays", {30'd0, st_int_err, st_conflict}, 32'd3);

        // R8: write-1-to-clear per bit.
        st_clear(2'b10);
        #1 check("R8 clear conflict only", {30'd0, st_int_err, st_conflict}, 32'd2);
        st_clear(2'b01);
        #1 check("R8 clear error", {30'd0, st_int_err, st_conflict}, 32'd0);
        probe("R8 overlap with clear", 16'h0300, 1, 1, 7'd2, 16'h0800, 2'b11);
        #1 check("R8 set wins over clear", {30'd0, st_int_err, st_conflict}, 32'd3);

        // R9: shadowed designated window.
        wr(2'd0, 4'b0100, 32'h0034_0000);
        rd_check("R9 low byte held in shadow", 2'd0, 32'h0000_0103);
        wr(2'd0, 4'b1010, {16'h1200, 1'b1, 15'h0});
        rd_check("R9 high byte commits", 2'd0, 32'h1234_8103);
        probe("R9 R6 designated hit", 16'h1236, 1, 0, 7'd1, 16'h0402, 2'b00);
        wr(2'd0, 4'b0100, 32'h0099_0000);
        probe("R9 address unchanged by low byte", 16'h1234, 1, 0, 7'd1, 16'h0400, 2'b00);
        wr(2'd0, 4'b1100, 32'h5678_0000);
        rd_check("R9 both bytes together", 2'd0, 32'h5678_8103);

        // R11: host reset.
        @(negedge clk); host_rst_n = 1'b0;
        @(negedge clk); host_rst_n = 1'b1;
        rd_check("R11 designated reloaded", 2'd0, 32'h0062_8103);
        rd_check("R11 other window cleared", 2'd1, 32'h0000_0207);
        rd_check("R11 win3 cleared", 2'd3, 32'h0000_040F);
        check("R11 status cleared", {30'd0, st_int_err, st_conflict}, 32'd0);
        probe("R11 reloaded address decodes", 16'h0061, 1, 0, 7'd1, 16'h0401, 2'b00);

        // R12: power-on reset clears designated window fully.
        @(negedge clk); por_rst_n = 1'b0;
        @(negedge clk); por_rst_n = 1'b1;
        rd_check("R12 designated cleared by por", 2'd0, 32'h0000_0103);

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule